// File: doc/BRIEF.md
# I2C Bus Phase Timing Generator

This block sets the pace of an I2C master. A bit-level engine asks it for one bus step at a time: a start condition, one data bit, a repeated start, or a stop condition. The block then counts out the phases of that step and fires one-clock tick strobes. The strobes tell the engine when to pull SCL low, when to release SCL, when to drop or release SDA, when to put the next data bit on the line, and when to sample SDA. The engine owns the lines, arbitration and byte handling. This block only says *when*.

Phase lengths come from cycle counts in three packed timing words per bank, plus a shared data-hold count. There is a fast-mode bank and a high-speed bank. Every transfer begins on the fast bank. After the engine reports that the master code has been sent, the block moves to the high-speed bank if high-speed operation was enabled. It stays there until the stop condition completes.

Counted phases advance on ticks of a prescaler that divides the clock by (divider+1). After SCL is released, a fixed settling window of 8 + 2·filter clocks is added. This window models the input synchroniser and glitch filter. As a result, one data bit spans (div+1)·(low+high+2) + 8 + 2·filter clocks.

Top module: `i2c_phase_timer`

## Requirements
- R1: A data-bit step ends with its SCL-fall strobe exactly (div+1)·(low+high+2) + 8 + 2·filter clocks after the clock edge that accepted it, where div, low, high and filter are those of the active bank and snapshot.
- R2: Every counted phase of N ticks lasts N·(div+1) clocks. The divider field covers division by 1 to 256.
- R3: A zero value in any of the following counts is treated as one tick: start setup, start hold, stop setup, data setup, repeated-start release or data hold.
- R4: Field positions are as follows.
  - Word 1: start setup in [31:24], start hold in [23:16], stop setup in [15:8].
  - Word 2: data setup in [31:24], SCL low in [15:8], SCL high in [7:0].
  - Word 3: divider in [23:16], repeated-start release in [7:0].
  - The 8-bit hold input carries the data hold shared by both banks.
  - All other word bits have no effect.
- R5: Command codes are 0 = start, 1 = data bit, 2 = repeated start and 3 = stop. A start step consists of two phases.
  - First, start-setup ticks, closed by an SDA-fall strobe.
  - Then, start-hold ticks, closed by an SCL-fall strobe.
- R6: A data-bit step consists of three phases.
  - A low phase of low+1 ticks, closed by an SCL-rise strobe. Within it, a drive strobe fires on the last clock of tick min(max(hold,1), low+1).
  - Next, 8 + 2·filter raw clocks, closed by a sample strobe.
  - Then, high+1 ticks, closed by an SCL-fall strobe.
- R7: A repeated-start step first spends release ticks, closed by an SCL-rise strobe. It then runs the two start phases.
- R8: A stop step consists of two phases.
  - Data-setup ticks, closed by an SCL-rise strobe.
  - Stop-setup ticks, closed by an SDA-rise strobe.
  - After this, the fast bank is active again from the next cycle.
- R9: All timing words, the hold count, the filter count and the high-speed enable are captured only when a start command is accepted. Changes at other times take effect at the next accepted start.
- R10: The bank flag moves to the high-speed bank one cycle after a master-code-done pulse, but only if all of the following hold.
  - The block is idle.
  - No command is presented in the same cycle.
  - High-speed operation was enabled at the last start.
  - Otherwise the pulse is ignored. An accepted start selects the fast bank.
- R11: Reset is synchronous and active low. In reset and right after it, the block is ready, every strobe is low and the fast bank is active.
- R12: A command is taken only while ready is high. Ready falls in the cycle after acceptance and returns one cycle after the step's final strobe. Commands presented while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Step request from the bit engine |
| cmd | input | 2 | Step code: 0 start, 1 data bit, 2 repeated start, 3 stop |
| mcode_done | input | 1 | Pulse: master code sent, move to high-speed timing |
| hs_enable | input | 1 | High-speed operation wanted (captured at start) |
| fs_tim1 | input | 32 | Fast bank word 1 |
| fs_tim2 | input | 32 | Fast bank word 2 |
| fs_tim3 | input | 32 | Fast bank word 3 |
| hs_tim1 | input | 32 | High-speed bank word 1 |
| hs_tim2 | input | 32 | High-speed bank word 2 |
| hs_tim3 | input | 32 | High-speed bank word 3 |
| hold_cfg | input | 8 | Data hold count, shared by both banks |
| filt_cycles | input | FLT_W (3) | Glitch filter length in clocks |
| cmd_ready | output | 1 | Idle, a command will be accepted |
| scl_fall_tick | output | 1 | Pull SCL low now |
| scl_rise_tick | output | 1 | Release SCL now |
| sda_fall_tick | output | 1 | Pull SDA low (start condition) now |
| sda_rise_tick | output | 1 | Release SDA (stop condition) now |
| drive_tick | output | 1 | Put the next data bit on SDA now |
| sample_tick | output | 1 | Sample SDA now |
| hs_bank_active | output | 1 | High-speed bank currently in use |

## Verification
Each strobe comes from registered phase state and is high in the last clock of its phase. The first busy clock is the one right after the accepting edge. A step of N ticks therefore puts its closing strobe N·(div+1) clocks after acceptance. Ready and the bank flag respond in the cycle after the edge that changes them. The bench builds the expected output vector of every future clock when it accepts a command and compares one vector per clock at the falling edge. It also measures the bit-step length against the closed formula, so an off-by-one in any phase, or a register picked up outside a start, shows up in the exact cycle it occurs.

// File: rtl/i2c_pt_pkg.sv
// Shared types for the I2C phase timer: step codes, phase states, the
// decoded timing bank and the word-unpacking helper.
package i2c_pt_pkg;

    localparam int FIELD_W = 8;            // every timing count is one byte
    localparam int WORD_W  = 32;           // packed timing word width
    localparam int TICK_W  = FIELD_W + 1;  // holds count+1 without wrap

    typedef enum logic [1:0] {
        CMD_START   = 2'd0,
        CMD_BIT     = 2'd1,
        CMD_RESTART = 2'd2,
        CMD_STOP    = 2'd3
    } cmd_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_SU_STA,
        PH_HD_STA,
        PH_LOW,
        PH_SETTLE,
        PH_HIGH,
        PH_REL,
        PH_SU_DAT,
        PH_SU_STO
    } phase_e;

    typedef struct packed {
        logic [FIELD_W-1:0] div;
        logic [FIELD_W-1:0] lo;
        logic [FIELD_W-1:0] hi;
        logic [FIELD_W-1:0] su_sta;
        logic [FIELD_W-1:0] hd_sta;
        logic [FIELD_W-1:0] su_sto;
        logic [FIELD_W-1:0] su_dat;
        logic [FIELD_W-1:0] rel;
    } bank_t;

    // Split three packed timing words into named fields.
    function automatic bank_t unpack_bank(input logic [WORD_W-1:0] w1,
                                          input logic [WORD_W-1:0] w2,
                                          input logic [WORD_W-1:0] w3);
        bank_t b;
        b.su_sta = w1[31:24];
        b.hd_sta = w1[23:16];
        b.su_sto = w1[15:8];
        b.su_dat = w2[31:24];
        b.lo     = w2[15:8];
        b.hi     = w2[7:0];
        b.div    = w3[23:16];
        b.rel    = w3[7:0];
        return b;
    endfunction

    // Zero counts run for one tick.
    function automatic logic [TICK_W-1:0] at_least_one(input logic [FIELD_W-1:0] v);
        return (v == '0) ? TICK_W'(1) : {1'b0, v};
    endfunction

endpackage

// File: rtl/i2c_pt_bank.sv
// Timing bank snapshot: decodes three packed words and holds the fields.
// Assumes the words are stable in the cycle where load is high; load is
// only raised when a start command is accepted.
module i2c_pt_bank
    import i2c_pt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] w1,
    input  logic [WORD_W-1:0] w2,
    input  logic [WORD_W-1:0] w3,
    output bank_t             cfg
);

    // Bits with no timing meaning in the word layout.
    logic unused_bits;
    assign unused_bits = ^{w1[7:0], w2[23:16], w3[31:24], w3[15:8]};

    // Capture the decoded fields on a start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (load) begin
            cfg <= unpack_bank(w1, w2, w3);
        end
    end

endmodule

// File: rtl/i2c_pt_prescale.sv
// Prescaler: emits a tick every (div+1) clocks, or every clock while raw
// is high. A restart realigns the count so each phase starts fresh.
module i2c_pt_prescale #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             raw,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] pre;

    assign tick = raw || (pre == div);

    // Count clocks inside one tick interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre <= '0;
        end else if (restart || tick) begin
            pre <= '0;
        end else begin
            pre <= pre + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_pt_seq.sv
// Phase sequencer: walks the phases of one bus step and raises the
// strobe that closes each phase. Assumes cfg, hold and filt stay stable
// while a step runs (they are snapshots owned by the top).
module i2c_pt_seq
    import i2c_pt_pkg::*;
#(
    parameter int FLT_W    = 3,
    parameter int OVH_BASE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd,
    input  bank_t            cfg,
    input  logic [FIELD_W-1:0] hold,
    input  logic [FLT_W-1:0] filt,
    input  logic             tick,
    output logic             raw,
    output logic             restart,
    output logic             ready,
    output logic             accept,
    output logic             scl_fall,
    output logic             scl_rise,
    output logic             sda_fall,
    output logic             sda_rise,
    output logic             drive,
    output logic             sample
);

    phase_e            phase, phase_nxt;
    logic [TICK_W-1:0] cnt;
    logic [TICK_W-1:0] len;
    logic [TICK_W-1:0] low_len;
    logic [TICK_W-1:0] hold_len;
    logic [TICK_W-1:0] drv_idx;
    logic              last;
    logic [FIELD_W-1:0] unused_div;

    assign unused_div = cfg.div;
    assign low_len    = {1'b0, cfg.lo} + 1'b1;
    assign hold_len   = at_least_one(hold);
    assign drv_idx    = ((hold_len < low_len) ? hold_len : low_len) - 1'b1;

    // Length of the current phase in ticks (raw clocks while settling).
    always_comb begin
        case (phase)
            PH_SU_STA: len = at_least_one(cfg.su_sta);
            PH_HD_STA: len = at_least_one(cfg.hd_sta);
            PH_LOW:    len = low_len;
            PH_SETTLE: len = TICK_W'(OVH_BASE) + TICK_W'({filt, 1'b0});
            PH_HIGH:   len = {1'b0, cfg.hi} + 1'b1;
            PH_REL:    len = at_least_one(cfg.rel);
            PH_SU_DAT: len = at_least_one(cfg.su_dat);
            PH_SU_STO: len = at_least_one(cfg.su_sto);
            default:   len = TICK_W'(1);
        endcase
    end

    assign ready   = (phase == PH_IDLE);
    assign accept  = ready && cmd_valid;
    assign raw     = (phase == PH_IDLE) || (phase == PH_SETTLE);
    assign last    = !ready && tick && (cnt == len - 1'b1);
    assign restart = accept || last;

    // Choose the next phase from a new command or the end of the current one.
    always_comb begin
        phase_nxt = phase;
        if (accept) begin
            case (cmd)
                CMD_START:   phase_nxt = PH_SU_STA;
                CMD_BIT:     phase_nxt = PH_LOW;
                CMD_RESTART: phase_nxt = PH_REL;
                default:     phase_nxt = PH_SU_DAT;
            endcase
        end else if (last) begin
            case (phase)
                PH_SU_STA: phase_nxt = PH_HD_STA;
                PH_LOW:    phase_nxt = PH_SETTLE;
                PH_SETTLE: phase_nxt = PH_HIGH;
                PH_REL:    phase_nxt = PH_SU_STA;
                PH_SU_DAT: phase_nxt = PH_SU_STO;
                default:   phase_nxt = PH_IDLE;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            phase <= phase_nxt;
        end
    end

    // Tick counter within the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (tick && !ready) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign sda_fall = last && (phase == PH_SU_STA);
    assign scl_fall = last && ((phase == PH_HD_STA) || (phase == PH_HIGH));
    assign scl_rise = last && ((phase == PH_LOW) || (phase == PH_REL) ||
                               (phase == PH_SU_DAT));
    assign sda_rise = last && (phase == PH_SU_STO);
    assign sample   = last && (phase == PH_SETTLE);
    assign drive    = (phase == PH_LOW) && tick && (cnt == drv_idx);

endmodule

// File: rtl/i2c_phase_timer.sv
// I2C phase timer top: snapshots both timing banks, the shared hold and
// the filter length at each accepted start, tracks which bank is in use,
// and drives the prescaler and phase sequencer from the active bank.
// Assumes the bit engine issues one step at a time and waits for ready.
module i2c_phase_timer
    import i2c_pt_pkg::*;
#(
    parameter int FLT_W    = 3,
    parameter int OVH_BASE = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd,
    input  logic               mcode_done,
    input  logic               hs_enable,
    input  logic [WORD_W-1:0]  fs_tim1,
    input  logic [WORD_W-1:0]  fs_tim2,
    input  logic [WORD_W-1:0]  fs_tim3,
    input  logic [WORD_W-1:0]  hs_tim1,
    input  logic [WORD_W-1:0]  hs_tim2,
    input  logic [WORD_W-1:0]  hs_tim3,
    input  logic [FIELD_W-1:0] hold_cfg,
    input  logic [FLT_W-1:0]   filt_cycles,
    output logic               cmd_ready,
    output logic               scl_fall_tick,
    output logic               scl_rise_tick,
    output logic               sda_fall_tick,
    output logic               sda_rise_tick,
    output logic               drive_tick,
    output logic               sample_tick,
    output logic               hs_bank_active
);

    localparam int NUM_BANKS = 2;
    localparam int BANK_HS   = 1;

    logic [WORD_W-1:0] bank_w1 [NUM_BANKS];
    logic [WORD_W-1:0] bank_w2 [NUM_BANKS];
    logic [WORD_W-1:0] bank_w3 [NUM_BANKS];
    bank_t             bank_cfg [NUM_BANKS];
    bank_t             act_cfg;

    logic               load;
    logic               accept;
    logic               tick;
    logic               raw;
    logic               restart;
    logic               hs_sel;
    logic               hs_snap;
    logic [FIELD_W-1:0] hold_snap;
    logic [FLT_W-1:0]   filt_snap;

    assign bank_w1[0]       = fs_tim1;
    assign bank_w2[0]       = fs_tim2;
    assign bank_w3[0]       = fs_tim3;
    assign bank_w1[BANK_HS] = hs_tim1;
    assign bank_w2[BANK_HS] = hs_tim2;
    assign bank_w3[BANK_HS] = hs_tim3;

    assign load = accept && (cmd == CMD_START);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        i2c_pt_bank u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load),
            .w1    (bank_w1[b]),
            .w2    (bank_w2[b]),
            .w3    (bank_w3[b]),
            .cfg   (bank_cfg[b])
        );
    end

    assign act_cfg = hs_sel ? bank_cfg[BANK_HS] : bank_cfg[0];

    // Shared snapshot of hold, filter length and the high-speed wish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_snap <= '0;
            filt_snap <= '0;
            hs_snap   <= 1'b0;
        end else if (load) begin
            hold_snap <= hold_cfg;
            filt_snap <= filt_cycles;
            hs_snap   <= hs_enable;
        end
    end

    // Bank selection: fast at start and after stop, high-speed after master code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_sel <= 1'b0;
        end else if (load || sda_rise_tick) begin
            hs_sel <= 1'b0;
        end else if (cmd_ready && !cmd_valid && mcode_done && hs_snap) begin
            hs_sel <= 1'b1;
        end
    end

    i2c_pt_prescale #(.DIV_W(FIELD_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .raw     (raw),
        .div     (act_cfg.div),
        .tick    (tick)
    );

    i2c_pt_seq #(.FLT_W(FLT_W), .OVH_BASE(OVH_BASE)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .cfg       (act_cfg),
        .hold      (hold_snap),
        .filt      (filt_snap),
        .tick      (tick),
        .raw       (raw),
        .restart   (restart),
        .ready     (cmd_ready),
        .accept    (accept),
        .scl_fall  (scl_fall_tick),
        .scl_rise  (scl_rise_tick),
        .sda_fall  (sda_fall_tick),
        .sda_rise  (sda_rise_tick),
        .drive     (drive_tick),
        .sample    (sample_tick)
    );

    assign hs_bank_active = hs_sel;

endmodule

// File: rtl/i2c_phase_timer_chk.sv
// Property checker for the I2C phase timer, bound to every instance.
module i2c_phase_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd,
    input logic       cmd_ready,
    input logic       scl_fall_tick,
    input logic       scl_rise_tick,
    input logic       sda_fall_tick,
    input logic       sda_rise_tick,
    input logic       drive_tick,
    input logic       sample_tick,
    input logic       hs_bank_active
);

    assert_busy_after_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    assert_ready_after_scl_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall_tick |=> cmd_ready);

    assert_edge_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_fall_tick, scl_rise_tick, sda_fall_tick, sda_rise_tick, sample_tick}));

    assert_strobes_only_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_tick || sample_tick || scl_fall_tick || sda_rise_tick) |-> !cmd_ready);

    assert_fast_after_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd == 2'd0) |=> !hs_bank_active);

    assert_fast_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sda_rise_tick |=> !hs_bank_active);

    assert_bank_stable_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready && !sda_rise_tick) |=> $stable(hs_bank_active));

endmodule

bind i2c_phase_timer i2c_phase_timer_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .cmd            (cmd),
    .cmd_ready      (cmd_ready),
    .scl_fall_tick  (scl_fall_tick),
    .scl_rise_tick  (scl_rise_tick),
    .sda_fall_tick  (sda_fall_tick),
    .sda_rise_tick  (sda_rise_tick),
    .drive_tick     (drive_tick),
    .sample_tick    (sample_tick),
    .hs_bank_active (hs_bank_active)
);

// File: tb/i2c_phase_timer_test.sv
`timescale 1ns/1ps
// Bench: a behavioural model expands each accepted step into a queue of
// expected per-clock output vectors, compared at every falling edge.
module i2c_phase_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd = 2'd0;
    logic        mcode_done = 1'b0;
    logic        hs_enable = 1'b0;
    logic [31:0] fs_tim1 = '0, fs_tim2 = '0, fs_tim3 = '0;
    logic [31:0] hs_tim1 = '0, hs_tim2 = '0, hs_tim3 = '0;
    logic [7:0]  hold_cfg = '0;
    logic [2:0]  filt_cycles = '0;
    logic cmd_ready, scl_fall_tick, scl_rise_tick, sda_fall_tick, sda_rise_tick;
    logic drive_tick, sample_tick, hs_bank_active;

    always #2.5 clk = ~clk;

    i2c_phase_timer uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .mcode_done(mcode_done), .hs_enable(hs_enable),
        .fs_tim1(fs_tim1), .fs_tim2(fs_tim2), .fs_tim3(fs_tim3),
        .hs_tim1(hs_tim1), .hs_tim2(hs_tim2), .hs_tim3(hs_tim3),
        .hold_cfg(hold_cfg), .filt_cycles(filt_cycles),
        .cmd_ready(cmd_ready), .scl_fall_tick(scl_fall_tick),
        .scl_rise_tick(scl_rise_tick), .sda_fall_tick(sda_fall_tick),
        .sda_rise_tick(sda_rise_tick), .drive_tick(drive_tick),
        .sample_tick(sample_tick), .hs_bank_active(hs_bank_active)
    );

    int checks = 0;
    int errors = 0;
    int cyc_n  = 0;

    // Bench-side programmed values and start-time snapshots, per bank.
    int cf_div[2], cf_lo[2], cf_hi[2], cf_ssta[2], cf_hsta[2], cf_ssto[2], cf_sdat[2], cf_rel[2];
    int sn_div[2], sn_lo[2], sn_hi[2], sn_ssta[2], sn_hsta[2], sn_ssto[2], sn_sdat[2], sn_rel[2];
    int cur_hold = 0, cur_f = 0, sn_hold = 0, sn_f = 0;
    bit cur_hsen = 0, sn_hsen = 0, m_hs = 0;

    // Vector bits: 7 ready, 6 scl_fall, 5 scl_rise, 4 sda_fall, 3 sda_rise, 2 drive, 1 sample, 0 hs.
    logic [7:0] q[$];
    logic [7:0] last_act;

    function automatic int c1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic set_bank(input int b, input int dv, input int lo, input int hi,
                            input int ssta, input int hsta, input int ssto,
                            input int sdat, input int rel);
        logic [31:0] w1, w2, w3;
        // R4: fields at their bit positions, junk in the unused bits.
        w1 = {ssta[7:0], hsta[7:0], ssto[7:0], 8'hA5};
        w2 = {sdat[7:0], 8'h5A, lo[7:0], hi[7:0]};
        w3 = {8'hC3, dv[7:0], 8'h3C, rel[7:0]};
        if (b == 0) begin fs_tim1 = w1; fs_tim2 = w2; fs_tim3 = w3; end
        else        begin hs_tim1 = w1; hs_tim2 = w2; hs_tim3 = w3; end
        cf_div[b] = dv; cf_lo[b] = lo; cf_hi[b] = hi; cf_ssta[b] = ssta;
        cf_hsta[b] = hsta; cf_ssto[b] = ssto; cf_sdat[b] = sdat; cf_rel[b] = rel;
    endtask

    task automatic set_shared(input int hold, input int f, input bit hsen);
        hold_cfg = hold[7:0]; filt_cycles = f[2:0]; hs_enable = hsen;
        cur_hold = hold; cur_f = f; cur_hsen = hsen;
    endtask

    task automatic push_phase(input int ticks, input int dv, input logic [7:0] endf,
                              input int drv_clk, input bit hs);
        int n;
        n = ticks * (dv + 1);
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            v = {7'b0, hs};
            if (i == n - 1) v = v | endf;
            if (i == drv_clk) v[2] = 1'b1;
            q.push_back(v);
        end
    endtask

    task automatic push_start(input int b, input bit hs);
        push_phase(c1(sn_ssta[b]), sn_div[b], 8'b0001_0000, -1, hs);
        push_phase(c1(sn_hsta[b]), sn_div[b], 8'b0100_0000, -1, hs);
    endtask

    task automatic accept_model(input logic [1:0] c);
        int b, l1, d;
        if (c == 2'd0) begin
            for (int k = 0; k < 2; k++) begin
                sn_div[k] = cf_div[k]; sn_lo[k] = cf_lo[k]; sn_hi[k] = cf_hi[k];
                sn_ssta[k] = cf_ssta[k]; sn_hsta[k] = cf_hsta[k]; sn_ssto[k] = cf_ssto[k];
                sn_sdat[k] = cf_sdat[k]; sn_rel[k] = cf_rel[k];
            end
            sn_hold = cur_hold; sn_f = cur_f; sn_hsen = cur_hsen;
            m_hs = 1'b0;
        end
        b = m_hs ? 1 : 0;
        case (c)
            2'd0: push_start(b, m_hs);
            2'd1: begin
                l1 = sn_lo[b] + 1;
                d  = (c1(sn_hold) < l1) ? c1(sn_hold) : l1;
                push_phase(l1, sn_div[b], 8'b0010_0000, d * (sn_div[b] + 1) - 1, m_hs);
                push_phase(8 + 2 * sn_f, 0, 8'b0000_0010, -1, m_hs);
                push_phase(sn_hi[b] + 1, sn_div[b], 8'b0100_0000, -1, m_hs);
            end
            2'd2: begin
                push_phase(c1(sn_rel[b]), sn_div[b], 8'b0010_0000, -1, m_hs);
                push_start(b, m_hs);
            end
            default: begin
                push_phase(c1(sn_sdat[b]), sn_div[b], 8'b0010_0000, -1, m_hs);
                push_phase(c1(sn_ssto[b]), sn_div[b], 8'b0000_1000, -1, m_hs);
                m_hs = 1'b0;
            end
        endcase
    endtask

    // One clock: compare outputs of this cycle, then drive this cycle's inputs.
    task automatic step(input bit v, input logic [1:0] c, input bit m, input string tag);
        logic [7:0] e, a;
        @(negedge clk);
        cyc_n++;
        if (q.size() > 0) e = q.pop_front();
        else              e = {1'b1, 6'b0, m_hs};
        a = {cmd_ready, scl_fall_tick, scl_rise_tick, sda_fall_tick, sda_rise_tick,
             drive_tick, sample_tick, hs_bank_active};
        last_act = a;
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s cycle %0d actual=%b expected=%b", tag, cyc_n, a, e);
        end
        cmd_valid = v; cmd = c; mcode_done = m;
        if (v && e[7]) accept_model(c);
        else if (m && e[7] && sn_hsen) m_hs = 1'b1;
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Issue one step in an idle cycle and follow it to completion.
    task automatic issue(input logic [1:0] c, input bit poke, input string tag);
        int n, fall_at, per, b;
        b = m_hs ? 1 : 0;
        per = (sn_div[b] + 1) * (sn_lo[b] + sn_hi[b] + 2) + 8 + 2 * sn_f;
        step(1'b1, c, 1'b0, tag);
        n = 0; fall_at = -1;
        while (q.size() > 0) begin
            step(poke, 2'd0, 1'b0, poke ? "R12" : tag);
            n++;
            if (last_act[6] && fall_at < 0) fall_at = n;
        end
        if (c == 2'd1) check_int("R1", fall_at, per);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, 1'b0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R11: reset state, during and after reset.
        idle(3, "R11");
        rst_n = 1'b1;
        idle(3, "R11");

        // Fast and high-speed banks, filter 1, hold 2, high speed wanted.
        set_bank(0, 1, 5, 4, 3, 2, 4, 2, 3);
        set_bank(1, 0, 3, 2, 2, 1, 2, 1, 2);
        set_shared(2, 1, 1'b1);
        issue(2'd0, 1'b0, "R5");
        issue(2'd1, 1'b0, "R6");
        issue(2'd1, 1'b1, "R12");
        step(1'b0, 2'd0, 1'b1, "R10");   // master code done: switch to high speed
        idle(2, "R10");
        issue(2'd1, 1'b0, "R2");
        issue(2'd2, 1'b0, "R7");
        issue(2'd1, 1'b0, "R6");
        issue(2'd3, 1'b0, "R8");
        idle(2, "R8");

        // R3: all zero counts, no filter, high speed not wanted.
        set_bank(0, 0, 0, 0, 0, 0, 0, 0, 0);
        set_shared(0, 0, 1'b0);
        issue(2'd0, 1'b0, "R3");
        issue(2'd1, 1'b0, "R3");
        step(1'b0, 2'd0, 1'b1, "R10");   // ignored: high speed not enabled
        idle(2, "R10");
        issue(2'd2, 1'b0, "R3");
        issue(2'd3, 1'b0, "R3");

        // R9: snapshot only at start; hold longer than the low phase (R6).
        set_bank(0, 2, 2, 1, 1, 1, 1, 1, 1);
        set_shared(10, 7, 1'b1);
        issue(2'd0, 1'b0, "R9");
        set_bank(0, 0, 6, 6, 5, 5, 5, 5, 5);
        set_shared(1, 2, 1'b1);
        issue(2'd1, 1'b0, "R9");
        issue(2'd1, 1'b0, "R6");
        step(1'b1, 2'd1, 1'b1, "R10");   // mcode with a command: stays fast
        while (q.size() > 0) step(1'b0, 2'd0, 1'b0, "R10");
        issue(2'd0, 1'b0, "R9");
        issue(2'd1, 1'b0, "R9");
        issue(2'd3, 1'b0, "R8");

        // R2: largest divider.
        set_bank(0, 255, 1, 0, 1, 1, 1, 1, 1);
        set_shared(1, 3, 1'b0);
        issue(2'd0, 1'b0, "R2");
        issue(2'd1, 1'b0, "R2");
        idle(3, "R2");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule